// File: doc/BRIEF.md
# Integer ALU with Set-Compare

This block is the integer execution stage of a 32-bit load-store core. Each cycle it can accept one operation, given as an operation code, two register operands and a 16-bit immediate. A mode flag decides whether the second operand comes from the register input or from the immediate. The immediate is sign-extended to 32 bits before it is used. The block adds, subtracts, performs bitwise logic and shifts. Its compares write a 0/1 value rather than condition flags. It also builds the upper half of a constant, and it raises a trap when signed arithmetic overflows.

The result and the trap are registered, so they appear one clock after the operation is presented. A move or a load-constant is coded as an add in which one source is the always-zero register, so the add path passes the other operand through unchanged.

Top module: `int_alu`

## Requirements
- R1: When `valid_i` is high at a rising clock edge, `result_o`, `ovf_trap_o` and `valid_o` show that operation's outcome after that edge. When `valid_i` is low, `valid_o` and `ovf_trap_o` drop to 0 and `result_o` keeps its value. While `rst_n` is low, all three outputs are 0.
- R2: Codes 0 (signed add), 1 (unsigned add), 2 (signed subtract) and 3 (unsigned subtract) produce a + op2 or a - op2, wrapped modulo 2^32. An add with op2 = 0, or with a = 0, returns the other operand unchanged.
- R3: Codes 4, 5 and 6 produce the bitwise AND, OR and XOR of a and op2.
- R4: When `use_imm_i` is 1, op2 is `imm_i` sign-extended to 32 bits; when it is 0, op2 is `b_i`.
- R5: Codes 7 (logical left), 8 (logical right) and 9 (arithmetic right) shift a by op2[4:0]. The upper bits of op2 are ignored.
- R6: Codes 10 to 15 compare a and op2 as signed two's-complement values, in the order equal, not equal, less than, greater than, less-or-equal, greater-or-equal. They write 1 when the relation holds and 0 when it does not.
- R7: Code 16 places `imm_i` in bits 31:16 of the result and zeros in bits 15:0, regardless of `use_imm_i`.
- R8: Codes 0 and 2 set `ovf_trap_o` exactly when the true signed result lies outside -2^31 to 2^31-1.
- R9: Codes 1 and 3, and every non-arithmetic code, never set `ovf_trap_o`.
- R10: Codes 17 to 31 produce a result of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 5 | Operation code |
| use_imm_i | input | 1 | Selects the sign-extended immediate as the second operand |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second register operand |
| imm_i | input | 16 | Immediate field |
| result_o | output | 32 | Registered result |
| ovf_trap_o | output | 1 | Signed overflow trap for the registered result |
| valid_o | output | 1 | Registered result is new this cycle |

## Verification
The only state is the output register, so a fault is visible one clock after the operation is issued. A wrong operand select or a wrong sign extension shows as a wrong result on the very next `valid_o`. A faulty overflow term shows as a missing or spurious trap on the boundary sums near plus and minus 2^31. A stale or clobbered output register shows as a changed `result_o` during idle cycles, one edge later.

// File: rtl/int_alu.sv
module int_alu #(
  parameter int W  = 32,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid_i,
  input  logic [4:0]    op_i,
  input  logic          use_imm_i,
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic [IW-1:0] imm_i,
  output logic [W-1:0]  result_o,
  output logic          ovf_trap_o,
  output logic          valid_o
);

  localparam int SHW = $clog2(W);

  localparam logic [4:0] OP_ADD  = 5'd0;
  localparam logic [4:0] OP_ADDU = 5'd1;
  localparam logic [4:0] OP_SUB  = 5'd2;
  localparam logic [4:0] OP_SUBU = 5'd3;
  localparam logic [4:0] OP_AND  = 5'd4;
  localparam logic [4:0] OP_OR   = 5'd5;
  localparam logic [4:0] OP_XOR  = 5'd6;
  localparam logic [4:0] OP_SLL  = 5'd7;
  localparam logic [4:0] OP_SRL  = 5'd8;
  localparam logic [4:0] OP_SRA  = 5'd9;
  localparam logic [4:0] OP_SEQ  = 5'd10;
  localparam logic [4:0] OP_SNE  = 5'd11;
  localparam logic [4:0] OP_SLT  = 5'd12;
  localparam logic [4:0] OP_SGT  = 5'd13;
  localparam logic [4:0] OP_SLE  = 5'd14;
  localparam logic [4:0] OP_SGE  = 5'd15;
  localparam logic [4:0] OP_LHI  = 5'd16;

  logic [W-1:0]   op2, sum, diff, nxt;
  logic [SHW-1:0] sh;
  logic           eq, lt, add_ovf, sub_ovf, nxt_trap;

  assign op2  = use_imm_i ? {{(W-IW){imm_i[IW-1]}}, imm_i} : b_i;
  assign sh   = op2[SHW-1:0];
  assign sum  = a_i + op2;
  assign diff = a_i - op2;
  assign eq   = (a_i == op2);
  assign lt   = ($signed(a_i) < $signed(op2));

  assign add_ovf = (a_i[W-1] == op2[W-1]) && (sum[W-1]  != a_i[W-1]);
  assign sub_ovf = (a_i[W-1] != op2[W-1]) && (diff[W-1] != a_i[W-1]);

  always_comb begin
    nxt      = '0;
    nxt_trap = 1'b0;
    case (op_i)
      OP_ADD:  begin nxt = sum;  nxt_trap = add_ovf; end
      OP_ADDU: nxt = sum;
      OP_SUB:  begin nxt = diff; nxt_trap = sub_ovf; end
      OP_SUBU: nxt = diff;
      OP_AND:  nxt = a_i & op2;
      OP_OR:   nxt = a_i | op2;
      OP_XOR:  nxt = a_i ^ op2;
      OP_SLL:  nxt = a_i << sh;
      OP_SRL:  nxt = a_i >> sh;
      OP_SRA:  nxt = W'($signed(a_i) >>> sh);
      OP_SEQ:  nxt = W'(eq);
      OP_SNE:  nxt = W'(!eq);
      OP_SLT:  nxt = W'(lt);
      OP_SGT:  nxt = W'(!lt && !eq);
      OP_SLE:  nxt = W'(lt || eq);
      OP_SGE:  nxt = W'(!lt);
      OP_LHI:  nxt = {imm_i, {(W-IW){1'b0}}};
      default: nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_o   <= '0;
      ovf_trap_o <= 1'b0;
      valid_o    <= 1'b0;
    end else begin
      valid_o    <= valid_i;
      ovf_trap_o <= valid_i && nxt_trap;
      if (valid_i) result_o <= nxt;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> valid_o); // R1
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> (!valid_o && !ovf_trap_o && $stable(result_o))); // R1
  AST_TRAP_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_trap_o |-> valid_o); // R8
  AST_NO_UNSIGNED_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && (op_i == OP_ADDU || op_i == OP_SUBU)) |=> !ovf_trap_o); // R9
  AST_NO_LOGIC_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i > OP_SUBU) |=> !ovf_trap_o); // R9
  AST_CMP_IS_BOOL: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i >= OP_SEQ && op_i <= OP_SGE) |=> (result_o[W-1:1] == '0)); // R6
  AST_LHI_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == OP_LHI) |=> (result_o[W-IW-1:0] == '0)); // R7
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i > OP_LHI) |=> (result_o == '0)); // R10

endmodule

// File: tb/test_int_alu.sv
module test_int_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [4:0]  op_i = '0;
  logic        use_imm_i = 1'b0;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic [15:0] imm_i = '0;
  logic [31:0] result_o;
  logic        ovf_trap_o;
  logic        valid_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  int_alu i_int_alu (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
    .use_imm_i(use_imm_i), .a_i(a_i), .b_i(b_i), .imm_i(imm_i),
    .result_o(result_o), .ovf_trap_o(ovf_trap_o), .valid_o(valid_o)
  );

  function automatic logic [31:0] sel2(input logic [31:0] b, input logic [15:0] imm, input logic ui);
    return ui ? {{16{imm[15]}}, imm} : b;
  endfunction

  function automatic logic [31:0] model(input logic [4:0] op, input logic [31:0] a,
                                        input logic [31:0] b, input logic [15:0] imm, input logic ui);
    logic [31:0] o2;
    longint sa, sb;
    o2 = sel2(b, imm, ui);
    sa = longint'($signed(a));
    sb = longint'($signed(o2));
    case (op)
      5'd0, 5'd1: return a + o2;
      5'd2, 5'd3: return a - o2;
      5'd4: return a & o2;
      5'd5: return a | o2;
      5'd6: return a ^ o2;
      5'd7: return a << o2[4:0];
      5'd8: return a >> o2[4:0];
      5'd9: return 32'(sa >>> o2[4:0]);
      5'd10: return {31'd0, sa == sb};
      5'd11: return {31'd0, sa != sb};
      5'd12: return {31'd0, sa <  sb};
      5'd13: return {31'd0, sa >  sb};
      5'd14: return {31'd0, sa <= sb};
      5'd15: return {31'd0, sa >= sb};
      5'd16: return {imm, 16'h0000};
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic trap_model(input logic [4:0] op, input logic [31:0] a,
                                      input logic [31:0] b, input logic [15:0] imm, input logic ui);
    longint sa, sb, r;
    sa = longint'($signed(a));
    sb = longint'($signed(sel2(b, imm, ui)));
    if (op == 5'd0) r = sa + sb;
    else if (op == 5'd2) r = sa - sb;
    else return 1'b0;
    return (r > 64'sd2147483647) || (r < -64'sd2147483648);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_op(input string req, input logic [4:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] imm, input logic ui);
    @(negedge clk);
    valid_i = 1'b1; op_i = op; a_i = a; b_i = b; imm_i = imm; use_imm_i = ui;
    @(negedge clk);
    check(req, result_o, model(op, a, b, imm, ui));
    check(req, {31'd0, ovf_trap_o}, {31'd0, trap_model(op, a, b, imm, ui)});
    check("R1", {31'd0, valid_o}, 32'd1);
    valid_i = 1'b0;
  endtask

  task automatic t_reset;
    check("R1", result_o, 32'd0);
    check("R1", {30'd0, valid_o, ovf_trap_o}, 32'd0);
  endtask

  task automatic t_addsub;
    do_op("R2", 5'd1, 32'hFFFF_FFFF, 32'd2, 16'h0, 1'b0);
    do_op("R2", 5'd3, 32'd0, 32'd1, 16'h0, 1'b0);
    do_op("R2", 5'd0, 32'h1234_5678, 32'd0, 16'h0, 1'b0);
    do_op("R2", 5'd0, 32'd0, 32'hCAFE_F00D, 16'h0, 1'b0);
    do_op("R2", 5'd2, 32'd100, 32'd58, 16'h0, 1'b0);
  endtask

  task automatic t_logic;
    do_op("R3", 5'd4, 32'hF0F0_1234, 32'h0FF0_FF00, 16'h0, 1'b0);
    do_op("R3", 5'd5, 32'hF0F0_1234, 32'h0FF0_FF00, 16'h0, 1'b0);
    do_op("R3", 5'd6, 32'hF0F0_1234, 32'h0FF0_FF00, 16'h0, 1'b0);
  endtask

  task automatic t_imm;
    do_op("R4", 5'd0, 32'd10, 32'h7777_7777, 16'hFFFE, 1'b1);
    do_op("R4", 5'd4, 32'hFFFF_FFFF, 32'd0, 16'h8001, 1'b1);
    do_op("R4", 5'd5, 32'd0, 32'hFFFF_0000, 16'h7001, 1'b1);
  endtask

  task automatic t_shift;
    do_op("R5", 5'd7, 32'h0000_0003, 32'h0000_0024, 16'h0, 1'b0);
    do_op("R5", 5'd8, 32'h8000_0000, 32'd31, 16'h0, 1'b0);
    do_op("R5", 5'd9, 32'h8000_0010, 32'd4, 16'h0, 1'b0);
    do_op("R5", 5'd9, 32'h8000_0000, 32'd0, 16'h001F, 1'b1);
    do_op("R5", 5'd8, 32'hF000_0000, 32'd0, 16'hFFE4, 1'b1);
  endtask

  task automatic t_compare;
    for (int op = 10; op <= 15; op++) begin
      do_op("R6", 5'(op), 32'hFFFF_FFFF, 32'd1, 16'h0, 1'b0);
      do_op("R6", 5'(op), 32'd7, 32'd7, 16'h0, 1'b0);
      do_op("R6", 5'(op), 32'd5, 32'h8000_0000, 16'h0, 1'b0);
    end
    do_op("R6", 5'd12, 32'hFFFF_FFFE, 32'd0, 16'hFFFF, 1'b1);
  endtask

  task automatic t_lhi;
    do_op("R7", 5'd16, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hBEEF, 1'b0);
    do_op("R7", 5'd16, 32'd0, 32'd0, 16'h8001, 1'b1);
  endtask

  task automatic t_overflow;
    do_op("R8", 5'd0, 32'h7FFF_FFFF, 32'd1, 16'h0, 1'b0);
    do_op("R8", 5'd0, 32'h8000_0000, 32'hFFFF_FFFF, 16'h0, 1'b0);
    do_op("R8", 5'd0, 32'h7FFF_FFFE, 32'd1, 16'h0, 1'b0);
    do_op("R8", 5'd2, 32'h8000_0000, 32'd1, 16'h0, 1'b0);
    do_op("R8", 5'd2, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 16'h0, 1'b0);
    do_op("R8", 5'd2, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 16'h0, 1'b0);
    do_op("R8", 5'd0, 32'h7FFF_FFF0, 32'd0, 16'h0010, 1'b1);
  endtask

  task automatic t_no_trap;
    do_op("R9", 5'd1, 32'h7FFF_FFFF, 32'd1, 16'h0, 1'b0);
    do_op("R9", 5'd3, 32'h8000_0000, 32'd1, 16'h0, 1'b0);
    do_op("R9", 5'd6, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0, 1'b0);
  endtask

  task automatic t_unused;
    do_op("R10", 5'd17, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 1'b1);
    do_op("R10", 5'd31, 32'h1234_5678, 32'h1, 16'h1, 1'b0);
  endtask

  task automatic t_hold;
    logic [31:0] prev;
    do_op("R1", 5'd0, 32'h7FFF_FFFF, 32'd1, 16'h0, 1'b0);
    prev = result_o;
    op_i = 5'd5; a_i = 32'hAAAA_AAAA; b_i = 32'h5555_5555;
    @(negedge clk);
    check("R1", result_o, prev);
    check("R1", {30'd0, valid_o, ovf_trap_o}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_addsub();
    t_logic();
    t_imm();
    t_shift();
    t_compare();
    t_lhi();
    t_overflow();
    t_no_trap();
    t_unused();
    t_hold();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule